// File: doc/BRIEF.md
# T1 Transmit Channel Conditioner

This block sits in the transmit datapath of a T1 framer, between the payload source and the framing/line-coding stages. It receives one DS0 byte at a time, tagged with its channel index and its frame number within a 12-frame superframe. It also receives the A and B signaling bits for that channel. It returns the byte after the per-channel substitutions have been made.

Two 24-bit bitmaps select the per-channel behaviour. The "clear" map exempts a channel from robbed-bit signaling and from zero suppression. The "idle" map replaces the channel's payload with an idle code. Three global inputs choose the idle code, enable robbed-bit signaling and enable zero suppression. The substitutions are applied in a fixed order: idle replacement, then signaling, then zero suppression. The result is registered.

Both bitmaps are loaded through a small write-only port with an address, data and a write enable. Line coding, framing-bit generation and the receive direction are handled by other blocks.

Top module: `t1tx_chan_ins`

## Requirements
- R1: Channel index n (0..23, meaning channels 1..24) is governed by bit n%8 of mask register n/8. Write address 0, 1 and 2 load the clear registers for channels 1-8, 9-16 and 17-24. Addresses 4, 5 and 6 load the idle registers in the same grouping. Writes to addresses 3 and 7 change nothing.
- R2: While reset is high, every mask bit is cleared, out_valid is 0 and out_data is 0x00.
- R3: A byte on a channel whose idle bit is 1 is replaced by 0x7F when idle_sel is 0, and by 0xFF when idle_sel is 1.
- R4: For a channel whose clear bit is 1 and whose idle bit is 0, the byte passes unchanged, whatever sig_en, zs_en and the frame number are.
- R5: With sig_en at 1 and the clear bit at 0, the LSB (bit 0) is set to the A bit in frame 6 and to the B bit in frame 12. The LSB is not touched in frames 1-5 and 7-11.
- R6: A channel whose idle bit is 1 and whose clear bit is 0 still has its idle code overwritten in bit 0 during signaling frames when sig_en is 1.
- R7: With zs_en at 1 and the clear bit at 0, a byte that is 0x00 after the idle and signaling stages is sent as 0x02. Zero suppression is the last stage, so a byte made zero by signaling is also substituted.
- R8: out_valid equals in_valid delayed by one clock. out_data takes the processed byte one clock after an in_valid cycle and holds its value while in_valid is 0.
- R9: With both mask bits 0 for a channel and sig_en and zs_en both 0, out_data equals the input byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask register write enable |
| cfg_addr | input | 3 | Mask register address (bit 2 picks idle/clear, bits 1:0 pick the group) |
| cfg_wdata | input | 8 | Mask register write data |
| idle_sel | input | 1 | Idle code select: 0 gives 0x7F, 1 gives 0xFF |
| sig_en | input | 1 | Robbed-bit signaling enable |
| zs_en | input | 1 | Zero-code suppression enable |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Payload byte |
| in_chan | input | 5 | Channel index 0..23 |
| in_frame | input | 4 | Frame number 1..12 within the superframe |
| in_sig_a | input | 1 | A signaling bit for this channel |
| in_sig_b | input | 1 | B signaling bit for this channel |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Processed byte |

## Verification
The properties assume that every valid byte carries a channel index below 24 and a frame number from 1 to 12. They also assume that the global control inputs are sampled with the byte they accompany. Mask writes are assumed to take effect only on bytes presented after the write edge. The stimulus keeps to these assumptions in three ways. It draws channel and frame values only from those ranges. It changes the global controls only together with a byte. It issues mask writes only while no byte is in flight.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] IDLE_CODE_LO = 8'h7F;
    localparam logic [BYTE_W-1:0] IDLE_CODE_HI = 8'hFF;
    localparam logic [BYTE_W-1:0] ZS_SUBST     = 8'h02;

    typedef enum logic [1:0] {
        SIG_NONE  = 2'd0,
        SIG_USE_A = 2'd1,
        SIG_USE_B = 2'd2
    } sig_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              clr;
        logic              idle;
    } chan_word_t;

    function automatic logic [BYTE_W-1:0] pick_idle(input logic sel);
        return sel ? IDLE_CODE_HI : IDLE_CODE_LO;
    endfunction

    function automatic logic [BYTE_W-1:0] put_sig(input logic [BYTE_W-1:0] b,
                                                   input sig_kind_e kind,
                                                   input logic a_bit,
                                                   input logic b_bit);
        logic [BYTE_W-1:0] r;
        r = b;
        case (kind)
            SIG_USE_A: r[0] = a_bit;
            SIG_USE_B: r[0] = b_bit;
            default:   r    = b;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] suppress_zero(input logic [BYTE_W-1:0] b);
        return (b == '0) ? ZS_SUBST : b;
    endfunction

endpackage

// File: rtl/t1tx_mask_bank.sv
module t1tx_mask_bank #(
    parameter int N_CH   = 24,
    parameter int BANK_W = 8,
    localparam int NB    = (N_CH + BANK_W - 1) / BANK_W,
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1,
    localparam int AW    = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [N_CH-1:0]   clear_vec,
    output logic [N_CH-1:0]   idle_vec
);
    logic [NB*BANK_W-1:0] clr_flat;
    logic [NB*BANK_W-1:0] idle_flat;

    // address bit AW-1 selects the idle group, low bits select the bank
    logic          sel_idle;
    logic [IW-1:0] sel_bank;
    assign sel_idle = addr[AW-1];
    assign sel_bank = addr[IW-1:0];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [BANK_W-1:0] clr_q;
        logic [BANK_W-1:0] idle_q;
        logic              hit;

        assign hit = we && (sel_bank == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                clr_q  <= '0;
                idle_q <= '0;
            end else if (hit) begin
                if (sel_idle) idle_q <= wdata;
                else          clr_q  <= wdata;
            end
        end

        assign clr_flat[g*BANK_W +: BANK_W]  = clr_q;
        assign idle_flat[g*BANK_W +: BANK_W] = idle_q;
    end

    assign clear_vec = clr_flat[N_CH-1:0];
    assign idle_vec  = idle_flat[N_CH-1:0];
endmodule

// File: rtl/t1tx_chan_lookup.sv
module t1tx_chan_lookup #(
    parameter int N_CH = 24,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic [CW-1:0]   chan,
    input  logic [N_CH-1:0] clear_vec,
    input  logic [N_CH-1:0] idle_vec,
    output logic            clr_bit,
    output logic            idle_bit
);
    // indexes beyond the last channel select neither mask
    always_comb begin
        clr_bit  = 1'b0;
        idle_bit = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (chan == CW'(i)) begin
                clr_bit  = clear_vec[i];
                idle_bit = idle_vec[i];
            end
        end
    end
endmodule

// File: rtl/t1tx_insert_path.sv
module t1tx_insert_path
    import t1tx_pkg::*;
#(
    parameter int SF_LEN    = 12,
    parameter int SIG_A_FR  = 6,
    parameter int SIG_B_FR  = 12,
    localparam int FW       = $clog2(SF_LEN + 1)
) (
    input  chan_word_t        word_in,
    input  logic [FW-1:0]     frame,
    input  logic              sig_a,
    input  logic              sig_b,
    input  logic              idle_sel,
    input  logic              sig_en,
    input  logic              zs_en,
    output logic [BYTE_W-1:0] byte_out
);
    sig_kind_e  kind;
    chan_word_t st_idle;
    chan_word_t st_sig;
    chan_word_t st_zs;

    always_comb begin
        if (frame == FW'(SIG_A_FR))      kind = SIG_USE_A;
        else if (frame == FW'(SIG_B_FR)) kind = SIG_USE_B;
        else                             kind = SIG_NONE;
    end

    // stage 1: idle code replacement
    always_comb begin
        st_idle = word_in;
        if (word_in.idle) st_idle.data = pick_idle(idle_sel);
    end

    // stage 2: robbed-bit signaling, skipped on clear channels
    always_comb begin
        st_sig = st_idle;
        if (sig_en && !st_idle.clr)
            st_sig.data = put_sig(st_idle.data, kind, sig_a, sig_b);
    end

    // stage 3: zero-code suppression, last in the chain
    always_comb begin
        st_zs = st_sig;
        if (zs_en && !st_sig.clr)
            st_zs.data = suppress_zero(st_sig.data);
    end

    assign byte_out = st_zs.data;
endmodule

// File: rtl/t1tx_chan_ins.sv
module t1tx_chan_ins
    import t1tx_pkg::*;
#(
    parameter int N_CH     = 24,
    parameter int BANK_W   = 8,
    parameter int SF_LEN   = 12,
    parameter int SIG_A_FR = 6,
    parameter int SIG_B_FR = 12,
    localparam int CW      = $clog2(N_CH),
    localparam int FW      = $clog2(SF_LEN + 1),
    localparam int NB      = (N_CH + BANK_W - 1) / BANK_W,
    localparam int IW      = (NB > 1) ? $clog2(NB) : 1,
    localparam int AW      = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [BANK_W-1:0] cfg_wdata,
    input  logic              idle_sel,
    input  logic              sig_en,
    input  logic              zs_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [CW-1:0]     in_chan,
    input  logic [FW-1:0]     in_frame,
    input  logic              in_sig_a,
    input  logic              in_sig_b,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    logic [N_CH-1:0]   clear_vec;
    logic [N_CH-1:0]   idle_vec;
    logic              clr_bit;
    logic              idle_bit;
    chan_word_t        word;
    logic [BYTE_W-1:0] result;

    t1tx_mask_bank #(.N_CH(N_CH), .BANK_W(BANK_W)) u_masks (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .clear_vec (clear_vec),
        .idle_vec  (idle_vec)
    );

    t1tx_chan_lookup #(.N_CH(N_CH)) u_lookup (
        .chan      (in_chan),
        .clear_vec (clear_vec),
        .idle_vec  (idle_vec),
        .clr_bit   (clr_bit),
        .idle_bit  (idle_bit)
    );

    always_comb begin
        word.data = in_data;
        word.clr  = clr_bit;
        word.idle = idle_bit;
    end

    t1tx_insert_path #(
        .SF_LEN   (SF_LEN),
        .SIG_A_FR (SIG_A_FR),
        .SIG_B_FR (SIG_B_FR)
    ) u_path (
        .word_in  (word),
        .frame    (in_frame),
        .sig_a    (in_sig_a),
        .sig_b    (in_sig_b),
        .idle_sel (idle_sel),
        .sig_en   (sig_en),
        .zs_en    (zs_en),
        .byte_out (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= result;
        end
    end
endmodule

// File: rtl/t1tx_chan_ins_chk.sv
module t1tx_chan_ins_chk #(
    parameter int N_CH     = 24,
    parameter int SF_LEN   = 12,
    parameter int SIG_A_FR = 6,
    parameter int SIG_B_FR = 12,
    localparam int CW      = $clog2(N_CH),
    localparam int FW      = $clog2(SF_LEN + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            idle_sel,
    input logic            sig_en,
    input logic            zs_en,
    input logic            in_valid,
    input logic [7:0]      in_data,
    input logic [CW-1:0]   in_chan,
    input logic [FW-1:0]   in_frame,
    input logic            in_sig_a,
    input logic            in_sig_b,
    input logic            out_valid,
    input logic [7:0]      out_data,
    input logic [N_CH-1:0] clear_vec,
    input logic [N_CH-1:0] idle_vec
);
    logic       c_clr;
    logic       c_idle;
    logic       c_sigfr;
    logic [7:0] c_code;

    assign c_clr   = (in_chan < CW'(N_CH)) ? clear_vec[in_chan] : 1'b0;
    assign c_idle  = (in_chan < CW'(N_CH)) ? idle_vec[in_chan]  : 1'b0;
    assign c_sigfr = (in_frame == FW'(SIG_A_FR)) || (in_frame == FW'(SIG_B_FR));
    assign c_code  = idle_sel ? 8'hFF : 8'h7F;

    assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (in_chan < CW'(N_CH)) && (in_frame != '0) && (in_frame <= FW'(SF_LEN)));

    assert_mask_reset_R2: assert property (@(posedge clk)
        $fell(rst) |-> (clear_vec == '0) && (idle_vec == '0) && !out_valid && (out_data == 8'h00));

    assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && c_idle && !(sig_en && !c_clr && c_sigfr)
        |=> out_data == ($past(idle_sel) ? 8'hFF : 8'h7F));

    assert_clear_pass_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && c_clr && !c_idle |=> out_data == $past(in_data));

    assert_sig_a_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && sig_en && !c_clr && (in_frame == FW'(SIG_A_FR))
        |=> out_data[0] == $past(in_sig_a));

    assert_sig_b_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && sig_en && !c_clr && (in_frame == FW'(SIG_B_FR))
        |=> out_data[0] == $past(in_sig_b));

    assert_sig_on_idle_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && sig_en && c_idle && !c_clr && (in_frame == FW'(SIG_A_FR))
        |=> out_data == {$past(c_code[7:1]), $past(in_sig_a)});

    assert_zs_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && zs_en && !c_clr |=> out_data != 8'h00);

    assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_data));

    assert_plain_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && !c_clr && !c_idle && !sig_en && !zs_en |=> out_data == $past(in_data));
endmodule

bind t1tx_chan_ins t1tx_chan_ins_chk #(
    .N_CH     (N_CH),
    .SF_LEN   (SF_LEN),
    .SIG_A_FR (SIG_A_FR),
    .SIG_B_FR (SIG_B_FR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .idle_sel  (idle_sel),
    .sig_en    (sig_en),
    .zs_en     (zs_en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_chan   (in_chan),
    .in_frame  (in_frame),
    .in_sig_a  (in_sig_a),
    .in_sig_b  (in_sig_b),
    .out_valid (out_valid),
    .out_data  (out_data),
    .clear_vec (clear_vec),
    .idle_vec  (idle_vec)
);

// File: tb/sim_t1tx_chan_ins.sv
module sim_t1tx_chan_ins;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       idle_sel = 1'b0;
    logic       sig_en = 1'b0;
    logic       zs_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [4:0] in_chan = '0;
    logic [3:0] in_frame = 4'd1;
    logic       in_sig_a = 1'b0;
    logic       in_sig_b = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    t1tx_chan_ins u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .idle_sel(idle_sel), .sig_en(sig_en),
        .zs_en(zs_en), .in_valid(in_valid), .in_data(in_data),
        .in_chan(in_chan), .in_frame(in_frame), .in_sig_a(in_sig_a),
        .in_sig_b(in_sig_b), .out_valid(out_valid), .out_data(out_data)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    int         cyc   = 0;
    logic [23:0] m_clr  = '0;
    logic [23:0] m_idle = '0;
    logic [7:0]  q_exp[$];
    string       q_tag[$];
    logic [7:0]  last_out = '0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // expected value computed from the requirements
    function automatic logic [7:0] model(input logic [7:0] d, input int ch, input int fr,
                                         input logic a, input logic b);
        logic [7:0] x;
        x = d;
        if (m_idle[ch]) x = idle_sel ? 8'hFF : 8'h7F;
        if (sig_en && !m_clr[ch]) begin
            if (fr == 6)  x[0] = a;
            if (fr == 12) x[0] = b;
        end
        if (zs_en && !m_clr[ch] && x == 8'h00) x = 8'h02;
        return x;
    endfunction

    task automatic send(input logic [7:0] d, input int ch, input int fr,
                        input logic a, input logic b, input string tag);
        in_valid = 1'b1;
        in_data  = d;
        in_chan  = 5'(ch);
        in_frame = 4'(fr);
        in_sig_a = a;
        in_sig_b = b;
        q_exp.push_back(model(d, ch, fr, a, b));
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_data = 8'(i * 37 + 5);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a <= 3'd2)                     m_clr[int'(a)*8 +: 8] = d;
        else if (a >= 3'd4 && a <= 3'd6)   m_idle[(int'(a)-4)*8 +: 8] = d;
    endtask

    task automatic sweep(input int fr, input string tag);
        for (int ch = 0; ch < 24; ch++)
            send(8'($urandom_range(0, 255)), ch, fr, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), tag);
        gap(2);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst) begin
            last_out = 8'h00;
        end else if (out_valid) begin
            if (q_exp.size() == 0) begin
                check("R8", 8'hEE, 8'h00);
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, out_data, e);
            end
            last_out = out_data;
        end else begin
            check("R8", out_data, last_out);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R2", {7'd0, out_valid}, 8'h00);
        check("R2", out_data, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        // R9 / R2: plain pass-through with reset masks
        sweep(1, "R9");
        sweep(6, "R2");

        // R3 / R1: idle on channels 1, 16, 24
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h80);
        wr(3'd6, 8'h80);
        idle_sel = 1'b0;
        sweep(3, "R3");
        idle_sel = 1'b1;
        sweep(3, "R3");
        send(8'h12, 0, 2, 0, 0, "R1");
        send(8'h12, 15, 2, 0, 0, "R1");
        send(8'h12, 23, 2, 0, 0, "R1");
        send(8'h12, 14, 2, 0, 0, "R1");
        gap(2);

        // R1: unused addresses change nothing
        wr(3'd3, 8'hFF);
        wr(3'd7, 8'hFF);
        sweep(4, "R1");

        // R5 / R6 / R4: signaling in every frame, clear on channels 9..16 and 24
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h80);
        sig_en = 1'b1;
        idle_sel = 1'b0;
        for (int fr = 1; fr <= 12; fr++) sweep(fr, "R5");
        send(8'hAA, 0, 6, 0, 1, "R6");
        send(8'hAA, 0, 12, 0, 1, "R6");
        send(8'hAA, 23, 6, 0, 1, "R4");
        send(8'hAB, 10, 12, 1, 0, "R4");
        gap(1);

        // R7: zero suppression, including zero made by signaling
        zs_en = 1'b1;
        send(8'h00, 2, 1, 0, 0, "R7");
        send(8'h01, 3, 6, 0, 0, "R7");
        send(8'h01, 3, 12, 1, 0, "R7");
        send(8'h00, 9, 6, 0, 0, "R4");
        send(8'h00, 5, 3, 0, 0, "R7");
        gap(3);
        for (int fr = 1; fr <= 12; fr++) sweep(fr, "R7");

        // R2: reset mid-run returns masks to zero
        rst = 1'b1;
        m_clr = '0;
        m_idle = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        sig_en = 1'b0;
        zs_en = 1'b0;
        @(negedge clk);
        sweep(6, "R2");
        send(8'h00, 0, 1, 0, 0, "R9");
        send(8'hFF, 23, 12, 1, 1, "R9");
        gap(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule